// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key FIFO

This block walks a key matrix of up to 16 rows and 8 columns. A 4-bit row count goes out to an external 4-to-16 decoder, which strobes one row at a time. Eight return inputs report which columns of the strobed row are closed. Inside each row the block takes one column per scan tick. A programmable prescaler sets how many clocks pass between ticks, and so sets both the scan rate and the debounce time.

A closure is accepted after it has been sampled on two full passes of the matrix in a row. The block then builds a key byte that carries the live state of the control and shift inputs and pushes it into an eight-entry queue. The arbitration mode can be changed at run time. In N-key rollover mode, every key held at once is queued. In two-key lockout mode, an accepted key that is still held blocks every other key.

The host drains the queue over a valid/ready stream. The keyboard side has no back-pressure: a key accepted while the queue is full is discarded and raises a sticky overrun flag. A one-cycle status-read strobe clears that flag. An interrupt line is high while the queue holds any entry.

Top module: `kbd_scan_fifo`

## Requirements
- R1: After reset `scan_row` is 0. It counts 0,1,…,15 and wraps to 0, and it changes exactly once every 8*(`cfg_div`+1) clock cycles.
- R2: `ret_lines[c]` high means the key at row `scan_row`, column c is closed. The byte queued for it is bit 7 = control, bit 6 = shift, bits 5:3 = row bits 2:0, bits 2:0 = column.
- R3: A key is accepted only when it reads closed on two consecutive passes of its row. A closure that lasts less than one full matrix pass (8*16*(`cfg_div`+1) clocks) queues nothing.
- R4: A key held for any length of time produces one entry. After it is released it can be accepted again.
- R5: With `cfg_nkro`=0, while one accepted key is still held, any other key that is pressed queues nothing.
- R6: With `cfg_nkro`=1, keys pressed together each produce their own entry. Keys in one row are queued in ascending column order.
- R7: The queue holds 8 entries. `key_data` shows the oldest entry while `key_valid` is high, and a cycle with `key_valid` and `key_ready` both high removes that entry. `fifo_level` gives the number of entries held.
- R8: `irq` is high exactly while the queue holds one or more entries.
- R9: A key accepted while the queue is full is dropped and sets `overrun`. `overrun` stays set until a cycle with `stat_rd` high clears it.
- R10: The shift and control bits of an entry are the values of `shift_key` and `ctrl_key` on the tick at which the key is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_lines | input | 8 | Column return inputs for the strobed row, high = closed |
| shift_key | input | 1 | Shift key level |
| ctrl_key | input | 1 | Control key level |
| cfg_nkro | input | 1 | 1 = N-key rollover, 0 = two-key lockout |
| cfg_div | input | 8 | Prescaler: clocks per scan tick minus one |
| scan_row | output | 4 | Row count to the external decoder |
| irq | output | 1 | Queue not empty |
| key_valid | output | 1 | Stream valid: an entry is available |
| key_ready | input | 1 | Stream ready: host takes the entry |
| key_data | output | 8 | Oldest key byte |
| fifo_level | output | 4 | Number of queued entries |
| stat_rd | input | 1 | Status read strobe, clears overrun |
| overrun | output | 1 | Sticky: a key was dropped on a full queue |

## Verification
Most state errors in this block show up late and only at the ports. A corrupted per-key debounce or reported bit shows as a missing, duplicated or premature entry one or two matrix passes later, which is hundreds of clocks at the fastest rate. A wrong held-key count shows as lockout blocking every later key, or letting an extra one through. A wrong row or column counter shows at once on `scan_row` timing, and also as wrong position fields in the queued bytes. A pointer or count error in the queue shows on the next pop, as out-of-order data or a wrong `fifo_level` or `irq`.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
  localparam int CODE_ROW_W = 3;
  localparam int CODE_COL_W = 3;

  typedef struct packed {
    logic                  ctrl;
    logic                  shift;
    logic [CODE_ROW_W-1:0] row;
    logic [CODE_COL_W-1:0] col;
  } key_code_t;

  localparam int CODE_W = $bits(key_code_t);
endpackage

// File: rtl/kbd_prescaler.sv
module kbd_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kbd_scan_ctr.sv
module kbd_scan_ctr #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o
);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_o <= '0;
      col_o <= '0;
    end else if (tick_i) begin
      if (col_o == COL_LAST) begin
        col_o <= '0;
        row_o <= (row_o == ROW_LAST) ? '0 : row_o + 1'b1;
      end else begin
        col_o <= col_o + 1'b1;
      end
    end
  end

  // R1
  row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(row_o));

  // R1
  col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> col_o != $past(col_o));
endmodule

// File: rtl/kbd_debounce.sv
module kbd_debounce #(
  parameter int ROWS = 16,
  parameter int COLS = 8,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int COL_W  = $clog2(COLS),
  localparam int KEYS   = ROWS * COLS,
  localparam int IDX_W  = $clog2(KEYS),
  localparam int HELD_W = $clog2(KEYS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             hit_i,
  input  logic             lockout_i,
  output logic             accept_o
);
  logic [KEYS-1:0]   seen_q;
  logic [KEYS-1:0]   rep_q;
  logic [HELD_W-1:0] held_q;
  logic [IDX_W-1:0]  idx;
  logic              cand;
  logic              release_ev;

  assign idx        = IDX_W'(row_i) * IDX_W'(COLS) + IDX_W'(col_i);
  assign cand       = tick_i && hit_i && seen_q[idx] && !rep_q[idx];
  assign accept_o   = cand && (!lockout_i || held_q == '0);
  assign release_ev = tick_i && !hit_i && rep_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      rep_q  <= '0;
      held_q <= '0;
    end else begin
      if (tick_i) seen_q[idx] <= hit_i;
      if (accept_o) begin
        rep_q[idx] <= 1'b1;
        held_q     <= held_q + 1'b1;
      end else if (release_ev) begin
        rep_q[idx] <= 1'b0;
        held_q     <= held_q - 1'b1;
      end
    end
  end

  // R4
  held_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> held_q == $past(held_q) + 1'b1);

  // R4
  held_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_q <= HELD_W'(KEYS));
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  output logic             valid_o,
  input  logic             ready_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [CNT_W-1:0] level_o,
  input  logic             ovr_clr_i,
  output logic             ovr_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full;
  assign valid_o = (cnt_q != '0);
  assign do_pop  = valid_o && ready_i;
  assign dout_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_o <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (!do_push && do_pop) cnt_q <= cnt_q - 1'b1;
      if (push_i && full)  ovr_o <= 1'b1;
      else if (ovr_clr_i)  ovr_o <= 1'b0;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R9
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> ovr_o);
endmodule

// File: rtl/kbd_scan_fifo.sv
module kbd_scan_fifo #(
  parameter int ROWS  = 16,
  parameter int COLS  = 8,
  parameter int DEPTH = 8,
  parameter int DIV_W = 8,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [COLS-1:0]           ret_lines,
  input  logic                      shift_key,
  input  logic                      ctrl_key,
  input  logic                      cfg_nkro,
  input  logic [DIV_W-1:0]          cfg_div,
  output logic [ROW_W-1:0]          scan_row,
  output logic                      irq,
  output logic                      key_valid,
  input  logic                      key_ready,
  output logic [kbd_pkg::CODE_W-1:0] key_data,
  output logic [CNT_W-1:0]          fifo_level,
  input  logic                      stat_rd,
  output logic                      overrun
);
  import kbd_pkg::*;

  logic             tick;
  logic [COL_W-1:0] scan_col;
  logic             key_accept;
  key_code_t        code;

  kbd_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .div_i(cfg_div), .tick_o(tick)
  );

  kbd_scan_ctr #(.ROWS(ROWS), .COLS(COLS)) u_scan (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .row_o(scan_row), .col_o(scan_col)
  );

  kbd_debounce #(.ROWS(ROWS), .COLS(COLS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .row_i(scan_row), .col_i(scan_col),
    .hit_i(ret_lines[scan_col]), .lockout_i(!cfg_nkro), .accept_o(key_accept)
  );

  always_comb begin
    code.ctrl  = ctrl_key;
    code.shift = shift_key;
    code.row   = CODE_ROW_W'(scan_row);
    code.col   = CODE_COL_W'(scan_col);
  end

  kbd_fifo #(.DEPTH(DEPTH), .WIDTH(CODE_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(key_accept), .din_i(code),
    .valid_o(key_valid), .ready_i(key_ready), .dout_o(key_data),
    .level_o(fifo_level), .ovr_clr_i(stat_rd), .ovr_o(overrun)
  );

  assign irq = key_valid;

  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && key_ready && fifo_level == CNT_W'(1) && !key_accept) |=> !irq);

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(key_accept));
endmodule

// File: tb/test_kbd_scan_fifo.sv
module test_kbd_scan_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ret_lines;
  logic       shift_key = 1'b0, ctrl_key = 1'b0, cfg_nkro = 1'b1;
  logic [7:0] cfg_div = 8'd0;
  logic [3:0] scan_row;
  logic       irq, key_valid, overrun;
  logic       key_ready = 1'b0, stat_rd = 1'b0;
  logic [7:0] key_data;
  logic [3:0] fifo_level;
  logic [7:0] kmap [16];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign ret_lines = kmap[scan_row];

  kbd_scan_fifo i_kbd_scan_fifo (
    .clk(clk), .rst_n(rst_n), .ret_lines(ret_lines), .shift_key(shift_key),
    .ctrl_key(ctrl_key), .cfg_nkro(cfg_nkro), .cfg_div(cfg_div),
    .scan_row(scan_row), .irq(irq), .key_valid(key_valid), .key_ready(key_ready),
    .key_data(key_data), .fifo_level(fifo_level), .stat_rd(stat_rd), .overrun(overrun)
  );

  function automatic logic [7:0] exp_code(input logic c, input logic s,
                                          input int r, input int col);
    return {c, s, 3'(r), 3'(col)};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    d = key_data;
    key_ready = 1'b1;
    @(negedge clk);
    key_ready = 1'b0;
  endtask

  task automatic clear_keys();
    for (int r = 0; r < 16; r++) kmap[r] = 8'h00;
  endtask

  task automatic row_period(output int p);
    logic [3:0] r0;
    r0 = scan_row;
    while (scan_row == r0) @(negedge clk);
    r0 = scan_row;
    p = 0;
    while (scan_row == r0) begin
      @(negedge clk);
      p++;
    end
  endtask

  initial begin
    logic [7:0] d;
    int p;
    clear_keys();
    void'($urandom(32'd4711));
    wait_clk(3);
    // R1 R8 R9 reset state
    check("R1 reset scan_row", scan_row, 0);
    check("R8 reset irq", irq, 0);
    check("R7 reset key_valid", key_valid, 0);
    check("R9 reset overrun", overrun, 0);
    rst_n = 1'b1;

    // R1 row period at two prescaler settings
    cfg_div = 8'd3;
    row_period(p);
    row_period(p);
    check("R1 period div3", p, 32);
    cfg_div = 8'd0;
    row_period(p);
    row_period(p);
    check("R1 period div0", p, 8);

    // R3 a closure shorter than one pass queues nothing
    kmap[5][2] = 1'b1;
    wait_clk(100);
    clear_keys();
    wait_clk(300);
    check("R3 short closure level", fifo_level, 0);

    // R2 R10 directed code format
    shift_key = 1'b1;
    kmap[9][6] = 1'b1;
    wait_clk(400);
    check("R8 irq with entry", irq, 1);
    pop(d);
    check("R2 R10 code row9 col6 shift", d, exp_code(0, 1, 9, 6));
    clear_keys();
    shift_key = 1'b0;
    wait_clk(300);

    // R4 long hold gives one entry, re-press gives another
    kmap[14][3] = 1'b1;
    wait_clk(800);
    check("R4 long hold level", fifo_level, 1);
    pop(d);
    check("R4 long hold code", d, exp_code(0, 0, 14, 3));
    wait_clk(2);
    check("R8 irq after last pop", irq, 0);
    clear_keys();
    wait_clk(300);
    check("R4 no entry on release", fifo_level, 0);
    kmap[14][3] = 1'b1;
    wait_clk(400);
    check("R4 re-press level", fifo_level, 1);
    pop(d);
    clear_keys();
    wait_clk(300);

    // R5 lockout
    cfg_nkro = 1'b0;
    kmap[2][4] = 1'b1;
    wait_clk(400);
    kmap[12][7] = 1'b1;
    wait_clk(400);
    check("R5 lockout level", fifo_level, 1);
    clear_keys();
    wait_clk(300);
    check("R5 lockout level after release", fifo_level, 1);
    pop(d);
    check("R5 lockout first key", d, exp_code(0, 0, 2, 4));
    cfg_nkro = 1'b1;

    // R6 rollover, same row, ascending columns
    while (scan_row != 4'd10) @(negedge clk);
    kmap[3][1] = 1'b1;
    kmap[3][5] = 1'b1;
    wait_clk(400);
    check("R6 rollover level", fifo_level, 2);
    pop(d);
    check("R6 first col", d, exp_code(0, 0, 3, 1));
    pop(d);
    check("R6 second col", d, exp_code(0, 0, 3, 5));
    clear_keys();
    wait_clk(300);

    // R9 overflow and clear, R7 depth
    for (int r = 0; r < 10; r++) kmap[r][0] = 1'b1;
    wait_clk(400);
    check("R7 full level", fifo_level, 8);
    check("R9 overrun set", overrun, 1);
    wait_clk(50);
    check("R9 overrun sticky", overrun, 1);
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    check("R9 overrun cleared", overrun, 0);
    for (int i = 0; i < 8; i++) pop(d);
    wait_clk(1);
    check("R7 drained level", fifo_level, 0);
    check("R8 irq drained", irq, 0);
    clear_keys();
    wait_clk(300);

    // random single keys, R2 R10
    for (int it = 0; it < 12; it++) begin
      int r, c;
      r = int'($urandom % 16);
      c = int'($urandom % 8);
      shift_key = 1'($urandom);
      ctrl_key  = 1'($urandom);
      cfg_nkro  = 1'($urandom);
      kmap[r][c] = 1'b1;
      wait_clk(400);
      check("R2 random level", fifo_level, 1);
      pop(d);
      check("R2 R10 random code", d, exp_code(ctrl_key, shift_key, r, c));
      clear_keys();
      wait_clk(300);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule